// File: doc/BRIEF.md
# Sign-Quadrant 8x8 Multiplier

This block multiplies two 8-bit operands and registers a 16-bit product. One control input picks how the operands are read: as plain unsigned values, or as two's complement values. In signed operation the top bit of each operand forms a two-bit quadrant code. The code names one of four sign cases: both positive, positive times negative, negative times positive, or both negative. The product for each case is built from the operand magnitudes, and the code picks the finished result, much as extra address lines would pick a region of a product table.

For unsigned operation the top bits are held low before they form the quadrant code. The code is therefore always the both-positive case, and all eight bits of each operand count as magnitude. The product is captured in an output register on every clock. A valid strobe rises on the first clock after reset and then stays high.

Top module: `qmul_sign_mode`

## Requirements
- R1: While reset is held and until the first clock edge after it is released, `product` is 0 and `valid` is 0.
- R2: When `signed_mode` is 0, operand bit 7 is masked out of the quadrant code. Operands with bit 7 set are still multiplied at their full unsigned value, e.g. 200 x 200 = 40000.
- R3: When `signed_mode` is 0, `product` is the unsigned product of the operands, from 0 up to 255 x 255 = 65025.
- R4: When `signed_mode` is 1 and both operands have bit 7 clear (quadrant 00), `product` is the non-negative product.
- R5: When `signed_mode` is 1 and exactly one operand has bit 7 set (quadrant 01 or 10), `product` is the negative product in 16-bit two's complement, e.g. 5 x -3 = 0xFFF1. If either operand is zero, it is 0.
- R6: When `signed_mode` is 1 and both operands have bit 7 set (quadrant 11), `product` is the positive product, e.g. -128 x -128 = 16384 (0x4000).
- R7: Inputs present before a rising edge appear on `product` right after that edge, and not before it. `valid` is 1 from the first edge after reset onwards.
- R8: A zero operand gives a zero product in every mode and quadrant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 8 | Multiplicand |
| op_b | input | 8 | Multiplier |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned operands |
| product | output | 16 | Registered product |
| valid | output | 1 | High once the product register holds a sampled result |

## Verification
The assertions check several properties on every cycle: the quadrant code is zero whenever unsigned operation is selected, and the unsigned product matches the operands of the cycle before. They also check the sign bit of each signed result against its quadrant, a zero product after any zero operand, and that valid stays high once it has risen. Only the bench's scenarios can show exact signed values at the edges of the range, such as -128 x -128 and -128 x 127. The bench also shows the full-range unsigned products with bit 7 set and the exact cycle on which a new result appears.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  typedef enum logic [1:0] {
    Q_PP = 2'b00,
    Q_PN = 2'b01,
    Q_NP = 2'b10,
    Q_NN = 2'b11
  } quad_e;

  localparam int unsigned QUAD_COUNT = 4;
endpackage

// File: rtl/qmul_quadrant.sv
module qmul_quadrant
  import qmul_pkg::*;
(
  input  logic  a_msb,
  input  logic  b_msb,
  input  logic  signed_mode,
  output quad_e code
);
  logic a_neg;
  logic b_neg;

  // unsigned operation masks both sign bits before they address a quadrant
  assign a_neg = a_msb & signed_mode;
  assign b_neg = b_msb & signed_mode;
  assign code  = quad_e'({a_neg, b_neg});
endmodule

// File: rtl/qmul_magnitude.sv
module qmul_magnitude
  import qmul_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  quad_e          code,
  output logic [W-1:0]   a_mag,
  output logic [W-1:0]   b_mag,
  output logic [2*W-1:0] mag_prod
);
  localparam int unsigned PW = 2 * W;

  function automatic logic [W-1:0] magnitude_of(input logic [W-1:0] x, input logic neg);
    magnitude_of = neg ? (~x + {{(W-1){1'b0}}, 1'b1}) : x;
  endfunction

  function automatic logic [PW-1:0] umul(input logic [W-1:0] x, input logic [W-1:0] y);
    umul = {{W{1'b0}}, x} * {{W{1'b0}}, y};
  endfunction

  assign a_mag    = magnitude_of(a, code[1]);
  assign b_mag    = magnitude_of(b, code[0]);
  assign mag_prod = umul(a_mag, b_mag);
endmodule

// File: rtl/qmul_sign_fix.sv
module qmul_sign_fix
  import qmul_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [2*W-1:0] mag_prod,
  input  quad_e          code,
  output logic [2*W-1:0] result
);
  localparam int unsigned PW = 2 * W;

  function automatic logic [PW-1:0] negate(input logic [PW-1:0] x);
    negate = ~x + {{(PW-1){1'b0}}, 1'b1};
  endfunction

  logic [PW-1:0] cand [QUAD_COUNT];

  // one candidate per quadrant; the code then addresses the table of candidates
  for (genvar q = 0; q < QUAD_COUNT; q++) begin : g_quad
    localparam bit NEG = (q == 1) || (q == 2);
    if (NEG) begin : g_neg
      assign cand[q] = negate(mag_prod);
    end else begin : g_pos
      assign cand[q] = mag_prod;
    end
  end

  assign result = cand[code];
endmodule

// File: rtl/qmul_sign_mode.sv
module qmul_sign_mode
  import qmul_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           signed_mode,
  output logic [2*W-1:0] product,
  output logic           valid
);
  localparam int unsigned PW = 2 * W;

  quad_e         quad_code;
  logic [W-1:0]  a_mag;
  logic [W-1:0]  b_mag;
  logic [PW-1:0] mag_prod;
  logic [PW-1:0] comb_prod;
  logic [PW-1:0] prod_q;
  logic          valid_q;

  qmul_quadrant u_quad (
    .a_msb       (op_a[W-1]),
    .b_msb       (op_b[W-1]),
    .signed_mode (signed_mode),
    .code        (quad_code)
  );

  qmul_magnitude #(.W(W)) u_mag (
    .a        (op_a),
    .b        (op_b),
    .code     (quad_code),
    .a_mag    (a_mag),
    .b_mag    (b_mag),
    .mag_prod (mag_prod)
  );

  qmul_sign_fix #(.W(W)) u_fix (
    .mag_prod (mag_prod),
    .code     (quad_code),
    .result   (comb_prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prod_q  <= comb_prod;
      valid_q <= 1'b1;
    end
  end

  assign product = prod_q;
  assign valid   = valid_q;

  // R2: unsigned operation never selects a signed quadrant
  a_r2_unsigned_quad: assert property (@(posedge clk) disable iff (!rst_n)
    !signed_mode |-> (quad_code == Q_PP));

  // R3: unsigned result equals the full-width product of the sampled operands
  a_r3_unsigned_prod: assert property (@(posedge clk) disable iff (!rst_n)
    !signed_mode |=> (prod_q == ({{W{1'b0}}, $past(op_a)} * {{W{1'b0}}, $past(op_b)})));

  // R4/R6: same-sign quadrants never yield a negative signed result
  a_r4_same_sign_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (signed_mode && (op_a[W-1] == op_b[W-1])) |=> !prod_q[PW-1]);

  // R5: mixed-sign quadrants with nonzero operands yield a negative result
  a_r5_mixed_sign_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (signed_mode && (op_a[W-1] != op_b[W-1]) && (a_mag != '0) && (b_mag != '0))
      |=> prod_q[PW-1]);

  // R8: any zero operand gives zero
  a_r8_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_a == '0) || (op_b == '0)) |=> (prod_q == '0));

  // R7: valid rises after reset and stays high
  a_r7_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |=> valid_q);
  a_r7_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);
endmodule

// File: tb/sim_qmul_sign_mode.sv
module sim_qmul_sign_mode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  op_a = 8'd0;
  logic [7:0]  op_b = 8'd0;
  logic        signed_mode = 1'b0;
  logic [15:0] product;
  logic        valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  qmul_sign_mode u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_a        (op_a),
    .op_b        (op_b),
    .signed_mode (signed_mode),
    .product     (product),
    .valid       (valid)
  );

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_of(input logic [7:0] a, input logic [7:0] b, input logic s);
    int r;
    if (s) r = int'($signed(a)) * int'($signed(b));
    else   r = int'(a) * int'(b);
    return r[15:0];
  endfunction

  // drive at a falling edge, look after the following rising edge
  task automatic run_one(input string req, input logic [7:0] a, input logic [7:0] b, input logic s);
    @(negedge clk);
    op_a = a; op_b = b; signed_mode = s;
    @(negedge clk);
    check16(req, product, expect_of(a, b, s));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check16("R1 product", product, 16'h0000);
    check16("R1 valid", {15'd0, valid}, 16'h0000);
    op_a = 8'd9; op_b = 8'd9;
    @(negedge clk);
    check16("R1 held", product, 16'h0000);
    rst_n = 1'b1;
    check16("R1 before edge", {15'd0, valid}, 16'h0000);
    @(negedge clk);
    check16("R7 valid", {15'd0, valid}, 16'h0001);
    check16("R7 first", product, 16'd81);
  endtask

  task automatic t_unsigned;
    run_one("R3 small", 8'd12, 8'd10, 1'b0);
    check16("R3 value", product, 16'd120);
    run_one("R3 max", 8'd255, 8'd255, 1'b0);
    check16("R3 65025", product, 16'd65025);
    run_one("R2 msb masked", 8'd200, 8'd200, 1'b0);
    check16("R2 40000", product, 16'd40000);
    run_one("R2 one msb", 8'd128, 8'd3, 1'b0);
  endtask

  task automatic t_signed_pp;
    run_one("R4 pp", 8'd100, 8'd7, 1'b1);
    run_one("R4 max", 8'd127, 8'd127, 1'b1);
    check16("R4 16129", product, 16'd16129);
  endtask

  task automatic t_signed_mixed;
    run_one("R5 pn", 8'd5, 8'hFD, 1'b1);
    check16("R5 0xFFF1", product, 16'hFFF1);
    run_one("R5 np", 8'h80, 8'd127, 1'b1);
    check16("R5 -16256", product, 16'hC080);
    run_one("R5 np one", 8'hFF, 8'd1, 1'b1);
    check16("R5 -1", product, 16'hFFFF);
  endtask

  task automatic t_signed_nn;
    run_one("R6 nn", 8'h80, 8'h80, 1'b1);
    check16("R6 16384", product, 16'h4000);
    run_one("R6 nn small", 8'hFE, 8'hFD, 1'b1);
    check16("R6 6", product, 16'd6);
  endtask

  task automatic t_zero;
    run_one("R8 neg x 0", 8'h80, 8'd0, 1'b1);
    check16("R8 zero", product, 16'd0);
    run_one("R8 0 x neg", 8'd0, 8'hFF, 1'b1);
    run_one("R8 unsigned", 8'd0, 8'd255, 1'b0);
  endtask

  task automatic t_latency;
    run_one("R7 base", 8'd3, 8'd4, 1'b0);
    @(negedge clk);
    op_a = 8'd50; op_b = 8'd2;
    #5;
    check16("R7 before edge", product, 16'd12);
    @(negedge clk);
    check16("R7 after edge", product, 16'd100);
    check16("R7 valid held", {15'd0, valid}, 16'h0001);
  endtask

  initial begin
    t_reset();
    t_unsigned();
    t_signed_pp();
    t_signed_mixed();
    t_signed_nn();
    t_zero();
    t_latency();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule